// File: doc/BRIEF.md
# Replicated Path Delay Probe

This block checks whether a copy of a logic path still meets its timing at the present supply and temperature. A launch register produces one controlled edge per enabled clock, toggling its value each cycle. The edge runs through a parameterised chain of stages. Each stage behaves as a two-input XOR whose second input is tied to a steady level that never masks a change. Because of this, every launched transition reaches the far end of the chain. One clock period later a capture register samples the chain output. A compare stage checks that sample against the value the launched edge should have produced and sets a sticky error flag when the two differ.

Each stage also has a block input that forces its output to a constant level. This lets a path that shares a stage with the one under test be cut out of the measurement. A forced stage stops the edge, so it causes a mismatch on purpose. A controller sweeps the supply and uses the error output to find the lowest safe operating point. It clears the flag between trials and holds the probe idle by dropping the enable.

Top module: `rpath_delay_probe`

## Requirements
- R1: After a synchronous active-high reset, `err_out` is 0.
- R2: With every force bit low and `edge_en` high, `err_out` stays 0 for any number of cycles. The launch register toggles on every enabled cycle. The chain output equals the launch value XORed with the stage-count parity, because the default steady side level is 1.
- R3: If any force bit is high while `edge_en` is high, the captured value stops tracking the launch. `err_out` then goes to 1 within three clock edges. A forced stage drives level 0.
- R4: Once set, `err_out` stays 1 after the force bits drop, as long as `edge_en` stays high and `err_clr` stays low.
- R5: `err_clr` high at an edge makes `err_out` 0 after that edge. This holds even when a mismatch is being judged in the same cycle.
- R6: While `edge_en` is low, the launch value holds and `err_out` is 0 after each edge, whatever the force bits are.
- R7: When `edge_en` rises again with every force bit low, no error is reported. The first sample compared after re-enable matches its expected value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_en | input | 1 | Enables edge launching and error judging |
| stage_force | input | STAGES | Per-stage force bit; high drives that stage's output to the fixed level |
| err_clr | input | 1 | Clears the sticky error flag |
| err_out | output | 1 | Sticky timing-fault flag |

## Verification
A clear request and a newly judged mismatch can land on the same edge. The bench provokes this by holding a force bit and pulsing `err_clr` on a cycle where the captured and expected values differ. Clear must win for that edge, and the flag must return on the next mismatch. The bench also drops `edge_en` while forcing stages, which checks that the idle hold also overrides a pending mismatch. Random mixes of enable, force and clear are judged against a cycle model built from the requirements.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    // Per-cycle comparison record carried through the detect stage.
    typedef struct packed {
        logic captured;
        logic expected;
        logic armed;
    } rpd_cmp_t;

    // Net inversion of a chain of XOR stages whose side inputs are tied to side_lvl.
    function automatic logic chain_flip(input int unsigned stages, input logic side_lvl);
        logic f;
        f = 1'b0;
        for (int unsigned i = 0; i < stages; i++) f = f ^ side_lvl;
        return f;
    endfunction

endpackage

// File: rtl/rpd_stage.sv
module rpd_stage #(
    parameter logic SIDE_LEVEL  = 1'b1,
    parameter logic FORCE_LEVEL = 1'b0
) (
    input  logic on_path,
    input  logic force_hold,
    output logic stage_out
);
    // XOR with a steady side input: every on-path change reaches the output.
    always_comb begin
        if (force_hold) stage_out = FORCE_LEVEL;
        else            stage_out = on_path ^ SIDE_LEVEL;
    end
endmodule

// File: rtl/rpd_launch.sv
module rpd_launch (
    input  logic clk,
    input  logic rst,
    input  logic edge_en,
    output logic launch_q
);
    always_ff @(posedge clk) begin
        if (rst)          launch_q <= 1'b0;
        else if (edge_en) launch_q <= ~launch_q;
    end

    p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        edge_en |=> (launch_q != $past(launch_q)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !edge_en |=> $stable(launch_q));
endmodule

// File: rtl/rpd_detect.sv
module rpd_detect #(
    parameter logic EXP_FLIP = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_en,
    input  logic err_clr,
    input  logic launch_q,
    input  logic path_end,
    output logic err_q
);
    import rpd_pkg::*;

    rpd_cmp_t cmp_q;
    logic     mismatch;

    // Capture one period after launch; expected value tracks the launch one cycle behind.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else begin
            cmp_q.captured <= path_end;
            cmp_q.expected <= launch_q ^ EXP_FLIP;
            cmp_q.armed    <= edge_en;
        end
    end

    // XNOR-style compare: low when equal.
    assign mismatch = cmp_q.armed & ~(cmp_q.captured ~^ cmp_q.expected);

    always_ff @(posedge clk) begin
        if (rst || err_clr || !edge_en) err_q <= 1'b0;
        else if (mismatch)              err_q <= 1'b1;
    end

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !err_q);

    p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !edge_en |=> !err_q);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (err_q && edge_en && !err_clr) |=> err_q);
endmodule

// File: rtl/rpath_delay_probe.sv
module rpath_delay_probe #(
    parameter int unsigned STAGES      = 4,
    parameter logic        SIDE_LEVEL  = 1'b1,
    parameter logic        FORCE_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_en,
    input  logic [STAGES-1:0] stage_force,
    input  logic              err_clr,
    output logic              err_out
);
    import rpd_pkg::*;

    localparam logic EXP_FLIP = chain_flip(STAGES, SIDE_LEVEL);

    logic              launch_q;
    logic [STAGES:0]   node;

    rpd_launch u_launch (
        .clk      (clk),
        .rst      (rst),
        .edge_en  (edge_en),
        .launch_q (launch_q)
    );

    assign node[0] = launch_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        rpd_stage #(
            .SIDE_LEVEL  (SIDE_LEVEL),
            .FORCE_LEVEL (FORCE_LEVEL)
        ) u_stage (
            .on_path    (node[g]),
            .force_hold (stage_force[g]),
            .stage_out  (node[g+1])
        );
    end

    rpd_detect #(
        .EXP_FLIP (EXP_FLIP)
    ) u_detect (
        .clk      (clk),
        .rst      (rst),
        .edge_en  (edge_en),
        .err_clr  (err_clr),
        .launch_q (launch_q),
        .path_end (node[STAGES]),
        .err_q    (err_out)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> !err_out);
endmodule

// File: tb/sim_rpath_delay_probe.sv
`timescale 1ns/1ps
module sim_rpath_delay_probe;
    localparam int unsigned N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         edge_en = 1'b0;
    logic [N-1:0] stage_force = '0;
    logic         err_clr = 1'b0;
    logic         err_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state built from the requirements.
    logic m_launch, m_cap, m_exp, m_arm, m_err;

    always #10 clk = ~clk;

    rpath_delay_probe #(.STAGES(N)) u0 (
        .clk(clk), .rst(rst), .edge_en(edge_en),
        .stage_force(stage_force), .err_clr(err_clr), .err_out(err_out)
    );

    function automatic logic path_value(input logic l, input logic [N-1:0] f);
        logic v;
        v = l;
        for (int i = 0; i < N; i++) v = f[i] ? 1'b0 : (v ^ 1'b1);
        return v;
    endfunction

    function automatic logic parity_flip();
        logic p;
        p = 1'b0;
        for (int i = 0; i < N; i++) p = ~p;
        return p;
    endfunction

    task automatic check(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s err_out=%b expected=%b at %0t", req, got, want, $time);
        end
    endtask

    // Drive inputs, take one edge, advance the model, sample at the falling edge.
    task automatic step(input logic en, input logic [N-1:0] f, input logic clr);
        logic n_err;
        edge_en = en; stage_force = f; err_clr = clr;
        @(posedge clk);
        if (rst) begin
            m_launch = 0; m_cap = 0; m_exp = 0; m_arm = 0; m_err = 0;
        end else begin
            n_err = (clr || !en) ? 1'b0 : (m_err | (m_arm & (m_cap != m_exp)));
            m_cap = path_value(m_launch, f);
            m_exp = m_launch ^ parity_flip();
            m_arm = en;
            if (en) m_launch = ~m_launch;
            m_err = n_err;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog err_out=%b expected=finish", err_out);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst = 1'b1;
        step(0, '0, 0);
        step(0, '0, 0);
        check("R1 reset", err_out, 1'b0);
        rst = 1'b0;

        // R2: long clean run
        for (int i = 0; i < 40; i++) begin
            step(1, '0, 0);
            check("R2 clean chain", err_out, m_err);
        end
        check("R2 no error after clean run", err_out, 1'b0);

        // R3: each single stage forced in turn
        for (int s = 0; s < N; s++) begin
            step(1, '0, 1);
            for (int k = 0; k < 3; k++) begin
                step(1, N'(1) << s, 0);
                check("R3 forced stage", err_out, m_err);
            end
            check("R3 flag set within three edges", err_out, 1'b1);
            // R4: force removed, flag stays
            for (int k = 0; k < 4; k++) step(1, '0, 0);
            check("R4 sticky after force drop", err_out, 1'b1);
        end

        // R5: clear coincides with ongoing mismatch
        step(1, 4'b0010, 0);
        step(1, 4'b0010, 0);
        step(1, 4'b0010, 1);
        check("R5 clear wins same cycle", err_out, 1'b0);
        step(1, 4'b0010, 0);
        check("R5 flag returns", err_out, m_err);
        step(1, 4'b0010, 0);
        check("R5 flag returns model", err_out, m_err);
        check("R5 flag back to one", err_out, 1'b1);

        // R6: idle with force bits high
        for (int k = 0; k < 5; k++) begin
            step(0, 4'b1111, 0);
            check("R6 idle holds clear", err_out, 1'b0);
        end

        // R7: re-enable cleanly
        step(0, '0, 0);
        for (int k = 0; k < 6; k++) begin
            step(1, '0, 0);
            check("R7 re-enable no false error", err_out, 1'b0);
        end

        // Random mix against the model
        for (int i = 0; i < 600; i++) begin
            logic en, clr;
            logic [N-1:0] f;
            en  = ($urandom_range(0, 9) != 0);
            clr = ($urandom_range(0, 15) == 0);
            f   = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
            step(en, f, clr);
            check("R2 R3 R4 R5 R6 random", err_out, m_err);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule